// File: doc/BRIEF.md
# Timer Pin GPIO and Edge-Interrupt Controller

This block manages the one I/O pin of a general-purpose timer channel. A small 32-bit register interface exposes a mode word and a status word. Depending on the pin-function code held in the mode word, the block does one of three things with the pin:

- It watches the pin for a chosen edge and records it as an event flag.
- It drives the pin as a general-purpose output, either push-pull or open-collector.
- It leaves the pin alone.

One interrupt line reports pending events when the mode word enables it.

The pin input is brought into the clock domain through a synchronizer chain. Its synchronized level can always be read from the status word. Edge detection compares the newest synchronized sample with the one before it. Event flags are cleared by writing ones to them. The counter, prescaler, compare and waveform functions of the timer are not part of this block. Their function codes are stored but leave the pin undriven.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the mode word reads 0, the status flags read 0, `pin_oe` is 0 and `irq` is 0.
- R2: The mode word sits at byte offset 0x0 and reads back exactly the 32 bits last written. Offsets 0x4 and 0x8 read as zero and ignore writes. An access is decoded only when address bits [1:0] are 0.
- R3: Status bit 8 at offset 0xC shows the pin level after a two-flop synchronizer, in every mode. A pin change becomes visible after the second rising clock edge.
- R4: With function code 1 (mode bits [2:0]), the edge select in mode bits [17:16] works as follows: 01 sets status bit 0 on a rising pin edge, 10 on a falling edge, 11 on either edge, and 00 on neither. The flag is set on the third clock edge after the pin changes.
- R5: With any function code other than 1, pin edges never set a status flag.
- R6: Writing status bits [3:0] with a 1 clears that flag and a 0 leaves it unchanged. If an edge sets bit 0 in the same cycle as a write clears it, bit 0 stays set.
- R7: `irq` is the OR of status bits [3:0] ANDed with mode bit 8, and it follows the registers with no added delay.
- R8: With function code 4, mode bits [5:4] set the pin drive. 00 and 01 leave the pin as an input (`pin_oe`=0), 10 drives it low and 11 drives it high.
- R9: With mode bit 24 set, the output is open-collector. A high request releases the pin (`pin_oe`=0) and a low request drives 0.
- R10: Function codes other than 4, including 2 and 3, never enable the pin driver, whatever bits [5:4] hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_addr | input | 4 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 1 | Pin level as seen from the pad |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can land in the same cycle are a flag set by a detected edge and a clearing write to the status word. The bench counts clock edges from a pin change so that the clearing write is captured on exactly the edge that sets the flag. It then expects bit 0 to read back as 1, and expects a second clearing write to bring it to 0. Sweeps over every function code, edge select and edge direction check both sides: the flag appears only for the matching combination, and the synchronized level in bit 8 is right.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_FLAGS = 4;

  localparam logic [2:0] FN_CAPTURE = 3'd1;
  localparam logic [2:0] FN_GPIO    = 3'd4;

  localparam int unsigned FN_LSB    = 0;
  localparam int unsigned DRV_LSB   = 4;
  localparam int unsigned IEN_BIT   = 8;
  localparam int unsigned EDGE_LSB  = 16;
  localparam int unsigned OC_BIT    = 24;
  localparam int unsigned LVL_BIT   = 8;

  localparam logic [1:0] WIDX_MODE  = 2'd0;
  localparam logic [1:0] WIDX_STAT  = 2'd3;

  typedef struct packed {
    logic [2:0] fn;
    logic [1:0] drv;
    logic       ien;
    logic [1:0] edge_sel;
    logic       oc;
  } mode_fields_t;

  function automatic mode_fields_t unpack_mode(input logic [DATA_W-1:0] w);
    mode_fields_t m;
    m.fn       = w[FN_LSB +: 3];
    m.drv      = w[DRV_LSB +: 2];
    m.ien      = w[IEN_BIT];
    m.edge_sel = w[EDGE_LSB +: 2];
    m.oc       = w[OC_BIT];
    return m;
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = pin_async;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  assign prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/tmr_pin_flags.sv
module tmr_pin_flags #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flags_q;
  logic [NF-1:0] flags_d;
  logic          upd_en;

  always_comb begin
    upd_en  = |{set_vec, clr_vec};
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/tmr_pin_drive.sv
module tmr_pin_drive
  import tmr_pin_pkg::*;
(
  input  mode_fields_t mode,
  output logic         pin_out,
  output logic         pin_oe
);
  logic want_drive;
  logic want_lvl;

  always_comb begin
    want_drive = (mode.fn == FN_GPIO) && mode.drv[1];
    want_lvl   = mode.drv[0];
    pin_oe     = 1'b0;
    pin_out    = 1'b0;
    if (want_drive) begin
      if (mode.oc) begin
        pin_oe  = ~want_lvl;
        pin_out = 1'b0;
      end else begin
        pin_oe  = 1'b1;
        pin_out = want_lvl;
      end
    end
  end
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pin_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  logic              hit_mode;
  logic              hit_stat;

  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] mode_d;
  logic              mode_en;
  mode_fields_t      mf;

  logic              lvl, rise, fall;
  logic              cap_hit;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flags_q;

  always_comb begin
    aligned  = (reg_addr[1:0] == 2'b00);
    widx     = reg_addr[ADDR_W-1:2];
    hit_mode = aligned && (widx == WIDX_W'(WIDX_MODE));
    hit_stat = aligned && (widx == WIDX_W'(WIDX_STAT));
  end

  always_comb begin
    mode_en = reg_wr && hit_mode;
    mode_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mf = unpack_mode(mode_q);

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_in),
    .level     (lvl),
    .rise      (rise),
    .fall      (fall)
  );

  always_comb begin
    cap_hit = (mf.fn == FN_CAPTURE) &&
              ((mf.edge_sel[0] && rise) || (mf.edge_sel[1] && fall));
    set_vec    = '0;
    set_vec[0] = cap_hit;
    clr_vec    = (reg_wr && hit_stat) ? reg_wdata[NUM_FLAGS-1:0] : '0;
  end

  tmr_pin_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags_q)
  );

  tmr_pin_drive u_drive (
    .mode    (mf),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  assign irq = mf.ien && (|flags_q);

  always_comb begin
    reg_rdata = '0;
    if (hit_mode) begin
      reg_rdata = mode_q;
    end else if (hit_stat) begin
      reg_rdata[NUM_FLAGS-1:0] = flags_q;
      reg_rdata[LVL_BIT]       = lvl;
    end
  end
endmodule

// File: rtl/tmr_pin_ctrl_chk.sv
module tmr_pin_ctrl_chk
  import tmr_pin_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] mode_q,
  input logic [NUM_FLAGS-1:0] flags_q,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              irq
);
  logic stat_clr0;
  assign stat_clr0 = reg_wr && (reg_addr == ADDR_W'(12)) && reg_wdata[0];

  AST_NO_DRIVE_OFF_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] != FN_GPIO) |-> !pin_oe); // R10

  AST_OC_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && mode_q[OC_BIT]) |-> !pin_out); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mode_q[IEN_BIT]); // R7

  AST_FLAG_SET_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[0]) |-> $past(mode_q[2:0] == FN_CAPTURE)); // R5

  AST_FLAG_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[0]) |-> $past(stat_clr0)); // R6

  AST_UPPER_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[NUM_FLAGS-1:1] == '0); // R4
endmodule

bind tmr_pin_ctrl tmr_pin_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mode_q    (mode_q),
  .flags_q   (flags_q),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/tmr_pin_ctrl_tb.sv
module tmr_pin_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, WDOG_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1 mode", v, 32'h0);
    rd(4'hC, v); chk("R1 flags", {28'h0, v[3:0]}, 32'h0);
    chk("R1 oe", {31'h0, pin_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 mode readback and reserved words
    wr(4'h0, 32'hA5A5_0F0F);
    rd(4'h0, v); chk("R2 readback", v, 32'hA5A5_0F0F);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, v); chk("R2 rsv4", v, 32'h0);
    rd(4'h8, v); chk("R2 rsv8", v, 32'h0);
    wr(4'h1, 32'h1234_5678);
    rd(4'h0, v); chk("R2 unaligned ignored", v, 32'hA5A5_0F0F);
    wr(4'h0, 32'h0);

    // R3 sync latency, R4 flag latency: capture rising
    wr(4'h0, 32'h0001_0001);
    wr(4'hC, 32'hF);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); rd(4'hC, v);
    chk("R3 lvl after 1 edge", {31'h0, v[8]}, 32'h0);
    @(negedge clk); rd(4'hC, v);
    chk("R3 lvl after 2 edges", {31'h0, v[8]}, 32'h1);
    chk("R4 flag not yet", {31'h0, v[0]}, 32'h0);
    @(negedge clk); rd(4'hC, v);
    chk("R4 flag after 3 edges", {31'h0, v[0]}, 32'h1);

    // R7 irq gating
    chk("R7 irq disabled", {31'h0, irq}, 32'h0);
    wr(4'h0, 32'h0001_0101);
    chk("R7 irq enabled", {31'h0, irq}, 32'h1);
    wr(4'hC, 32'h0);
    rd(4'hC, v); chk("R6 zero write keeps", {31'h0, v[0]}, 32'h1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R6 one write clears", {31'h0, v[0]}, 32'h0);
    chk("R7 irq after clear", {31'h0, irq}, 32'h0);

    // R6 set beats same-cycle clear
    pin_in = 1'b0; idle(4);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 4'hC; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'hC, v); chk("R6 set wins over clear", {31'h0, v[0]}, 32'h1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R6 second clear", {31'h0, v[0]}, 32'h0);
    wr(4'h0, 32'h0);

    // R4 R5 R3 sweep: function code x edge select x direction
    for (int fn = 0; fn < 8; fn++) begin
      for (int es = 0; es < 4; es++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic exp_f;
          pin_in = (dir == 0) ? 1'b0 : 1'b1;
          idle(4);
          wr(4'h0, {14'h0, es[1:0], 13'h0, fn[2:0]});
          wr(4'hC, 32'hF);
          @(negedge clk); pin_in = ~pin_in;
          idle(4);
          rd(4'hC, v);
          exp_f = (fn == 1) && ((dir == 0) ? es[0] : es[1]);
          chk(exp_f ? "R4 capture flag" : "R5 no flag", {31'h0, v[0]}, {31'h0, exp_f});
          chk("R3 level", {31'h0, v[8]}, {31'h0, pin_in});
        end
      end
    end
    wr(4'hC, 32'hF);

    // R8 R9 R10 drive sweep
    for (int fn = 0; fn < 8; fn++) begin
      for (int g = 0; g < 4; g++) begin
        for (int oc = 0; oc < 2; oc++) begin
          logic drv, lvl, e_oe;
          wr(4'h0, {7'h0, oc[0], 18'h0, g[1:0], 1'b0, fn[2:0]});
          #1;
          drv  = (fn == 4) && g[1];
          lvl  = g[0];
          e_oe = drv && !(oc[0] && lvl);
          if (fn != 4) chk("R10 no drive", {31'h0, pin_oe}, {31'h0, e_oe});
          else if (oc[0]) chk("R9 open collector oe", {31'h0, pin_oe}, {31'h0, e_oe});
          else chk("R8 gpio oe", {31'h0, pin_oe}, {31'h0, e_oe});
          if (e_oe) chk("R8 gpio level", {31'h0, pin_out}, {31'h0, lvl});
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule